// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers 32 interrupt request lines, remembers each rising edge as a pending event, and on every cycle picks the most urgent pending request that software has enabled. Software reaches it over a simple word-wide register bus. One register sets enable bits and another clears them. Eight priority registers each carry four byte-wide fields. Only the top three bits of every field are kept, so a field written as 0xA0 holds priority 5.

On the core side the block presents a request flag and a vector number. It raises the flag only when the winner is strictly more urgent than the level now running, where a lower number means more urgent. When the core accepts the request, the running level is pushed onto a small stack and the winner's priority becomes the new running level. A completion pulse pops the stack and returns to the level that was preempted. A global mask input silences the request flag without discarding any pending events.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A write to offset 0x100 sets enable bit n for each data bit n that is 1 and leaves the other enables unchanged; a read of 0x100 returns the current enables.
- R2: A write to offset 0x180 clears enable bit n for each data bit n that is 1 and leaves the others unchanged; a read of 0x180 also returns the current enables; any other unmapped word reads as zero.
- R3: Priority register k sits at offset 0x400 + 4k and holds requests 4k to 4k+3, request 4k+j in bits 8j+7 down to 8j; only the top 3 bits of each byte are stored, and the low 5 bits read as zero.
- R4: A pending bit is set on a rising edge of its request line, not by a held level, and is kept while the line is disabled, so it is signalled once enabled.
- R5: Among pending enabled requests, the one with the numerically lowest priority wins and its number appears on irq_vec; on a tie, the lowest request number wins.
- R6: irq_req is high only when the winner's priority is strictly lower than run_level; run_level is 8 when no handler runs, and an equal or higher value does not preempt.
- R7: An irq_ack while irq_req is high, without irq_done, sets run_level to the winner's priority and clears that pending bit; an irq_ack while irq_req is low has no effect.
- R8: irq_done pops run_level back to the level that was preempted; irq_done with no handler running leaves run_level at 8; when irq_done and irq_ack coincide, the ack is ignored.
- R9: While mask_i is high, irq_req stays low; the pending bits are kept and are signalled again once mask_i falls.
- R10: After reset all enables, priorities and pending bits are zero, run_level is 8 and irq_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 32 | Request lines, rising edge latched |
| mask_i | input | 1 | Global mask that blocks signalling |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_req | output | 1 | Winner may preempt the running level |
| irq_vec | output | 5 | Winning request number |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_done | input | 1 | Running handler has completed |
| run_level | output | 4 | Running priority level, 8 when idle |

## Verification
The hardest situation to reach is a nested state: one handler has been preempted by a more urgent one, other requests of equal priority are waiting, and a held line must not re-trigger. The stimulus programs distinct priorities and ties, then raises lines one at a time and accepts two nested vectors. It then completes them one by one, checking after each pop that an equal-priority waiter stays blocked and that a line still held high does not re-enter the race. Coinciding ack and done pulses, an ack with no request, and a done with nothing running are driven from that state to probe the stack edges.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int IRQ_CNT        = 32;
    localparam int PRIO_BITS      = 3;
    localparam int LVL_DEPTH      = 8;
    localparam int BUS_AW         = 12;
    localparam int BUS_DW         = 32;
    localparam int FIELD_W        = 8;
    localparam int FIELDS_PER_REG = BUS_DW / FIELD_W;

    localparam logic [BUS_AW-1:0] OFS_SET_EN    = 12'h100;
    localparam logic [BUS_AW-1:0] OFS_CLR_EN    = 12'h180;
    localparam logic [BUS_AW-1:0] OFS_PRIO_BASE = 12'h400;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SET_EN,
        SEL_CLR_EN,
        SEL_PRIO
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [BUS_AW-1:0] addr, input int nregs);
        int a;
        a = int'(addr);
        if (addr == OFS_SET_EN) return SEL_SET_EN;
        if (addr == OFS_CLR_EN) return SEL_CLR_EN;
        if (addr[1:0] == 2'b00 && a >= int'(OFS_PRIO_BASE) &&
            a < int'(OFS_PRIO_BASE) + 4 * nregs) return SEL_PRIO;
        return SEL_NONE;
    endfunction
endpackage

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs import irqc_pkg::*; #(
    parameter int NUM_IRQ = IRQ_CNT,
    parameter int PRIO_W  = PRIO_BITS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [BUS_AW-1:0]         addr,
    input  logic [BUS_DW-1:0]         wdata,
    output logic [BUS_DW-1:0]         rdata,
    output logic [NUM_IRQ-1:0]        en_q,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_q
);
    localparam int NREG   = NUM_IRQ / FIELDS_PER_REG;
    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    reg_sel_e          sel;
    logic [BUS_AW-1:0] off;
    logic [RIDX_W-1:0] ridx;

    assign sel  = decode_sel(addr, NREG);
    assign off  = addr - OFS_PRIO_BASE;
    assign ridx = off[RIDX_W+1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr && sel == SEL_SET_EN) begin
            en_q <= en_q | wdata[NUM_IRQ-1:0];
        end else if (wr && sel == SEL_CLR_EN) begin
            en_q <= en_q & ~wdata[NUM_IRQ-1:0];
        end
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_fld
        localparam int RSEL = i / FIELDS_PER_REG;
        localparam int BSEL = i % FIELDS_PER_REG;
        logic [PRIO_W-1:0] fld;
        always_ff @(posedge clk) begin
            if (rst) begin
                fld <= '0;
            end else if (wr && sel == SEL_PRIO && ridx == RIDX_W'(RSEL)) begin
                fld <= wdata[BSEL*FIELD_W + FIELD_W - 1 -: PRIO_W];
            end
        end
        assign prio_q[i*PRIO_W +: PRIO_W] = fld;
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_SET_EN, SEL_CLR_EN: rdata[NUM_IRQ-1:0] = en_q;
            SEL_PRIO: begin
                for (int b = 0; b < FIELDS_PER_REG; b++) begin
                    rdata[b*FIELD_W + FIELD_W - 1 -: PRIO_W] =
                        prio_q[(int'(ridx) * FIELDS_PER_REG + b) * PRIO_W +: PRIO_W];
                end
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
module irqc_arbiter import irqc_pkg::*; #(
    parameter int NUM_IRQ = IRQ_CNT,
    parameter int PRIO_W  = PRIO_BITS,
    parameter int VEC_W   = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_q,
    output logic                      win_valid,
    output logic [VEC_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!win_valid || prio_q[i*PRIO_W +: PRIO_W] < win_prio)) begin
                win_valid = 1'b1;
                win_idx   = VEC_W'(i);
                win_prio  = prio_q[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irqc_lvl_stack.sv
`timescale 1ns/1ps
module irqc_lvl_stack import irqc_pkg::*; #(
    parameter int DEPTH = LVL_DEPTH,
    parameter int LVL_W = PRIO_BITS + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] new_lvl,
    output logic [LVL_W-1:0] cur_lvl,
    output logic             empty,
    output logic             full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] IDLE = LVL_W'(1) << (LVL_W - 1);

    logic [LVL_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign wr_idx  = cnt[IDX_W-1:0];
    assign top_idx = wr_idx - IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_lvl <= IDLE;
            cnt     <= '0;
        end else if (push && !full) begin
            cur_lvl <= new_lvl;
            cnt     <= cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            cur_lvl <= mem[top_idx];
            cnt     <= cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) begin
            mem[wr_idx] <= cur_lvl;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl import irqc_pkg::*; #(
    parameter int NUM_IRQ     = IRQ_CNT,
    parameter int PRIO_W      = PRIO_BITS,
    parameter int STACK_DEPTH = LVL_DEPTH,
    localparam int VEC_W      = $clog2(NUM_IRQ),
    localparam int LVL_W      = PRIO_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               mask_i,
    input  logic               reg_wr,
    input  logic [BUS_AW-1:0]  reg_addr,
    input  logic [BUS_DW-1:0]  reg_wdata,
    output logic [BUS_DW-1:0]  reg_rdata,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    input  logic               irq_ack,
    input  logic               irq_done,
    output logic [LVL_W-1:0]   run_level
);
    logic [NUM_IRQ-1:0]        en_q;
    logic [NUM_IRQ*PRIO_W-1:0] prio_q;
    logic [NUM_IRQ-1:0]        irq_q;
    logic [NUM_IRQ-1:0]        pend_q;
    logic [NUM_IRQ-1:0]        clr_mask;
    logic                      win_valid;
    logic [PRIO_W-1:0]         win_prio;
    logic                      stk_empty;
    logic                      stk_full;
    logic                      accept;
    logic                      pop;

    irqc_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .en_q  (en_q),
        .prio_q(prio_q)
    );

    irqc_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
        .cand     (pend_q & en_q),
        .prio_q   (prio_q),
        .win_valid(win_valid),
        .win_idx  (irq_vec),
        .win_prio (win_prio)
    );

    irqc_lvl_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_stk (
        .clk    (clk),
        .rst    (rst),
        .push   (accept),
        .pop    (pop),
        .new_lvl({1'b0, win_prio}),
        .cur_lvl(run_level),
        .empty  (stk_empty),
        .full   (stk_full)
    );

    assign irq_req  = win_valid && !mask_i && !stk_full && ({1'b0, win_prio} < run_level);
    assign accept   = irq_ack && irq_req && !irq_done;
    assign pop      = irq_done && !stk_empty;
    assign clr_mask = accept ? (NUM_IRQ'(1) << irq_vec) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= '0;
            pend_q <= '0;
        end else begin
            irq_q  <= irq_i;
            pend_q <= (pend_q & ~clr_mask) | (irq_i & ~irq_q);
        end
    end
endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk import irqc_pkg::*; (
    input logic                    clk,
    input logic                    rst,
    input logic                    mask_i,
    input logic                    irq_req,
    input logic                    irq_ack,
    input logic                    irq_done,
    input logic [PRIO_BITS:0]      run_level,
    input logic                    reg_wr,
    input logic [BUS_AW-1:0]       reg_addr,
    input logic [BUS_DW-1:0]       reg_wdata,
    input logic [IRQ_CNT-1:0]      en_q
);
    localparam logic [PRIO_BITS:0] IDLE = (PRIO_BITS+1)'(1) << PRIO_BITS;

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (rst)
        mask_i |-> !irq_req); // R9

    AST_ACCEPT_RAISES: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && !irq_done) |=> (run_level < $past(run_level))); // R6

    AST_POP_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (irq_done && run_level != IDLE) |=> (run_level > $past(run_level))); // R8

    AST_IDLE_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq_done && run_level == IDLE) |=> (run_level == IDLE)); // R8

    AST_SET_EN_ONLY_SETS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_SET_EN) |=>
        (((en_q & $past(reg_wdata)) == $past(reg_wdata)) &&
         ((en_q & $past(en_q)) == $past(en_q)))); // R1

    AST_CLR_EN_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CLR_EN) |=>
        (((en_q & $past(reg_wdata)) == '0) &&
         ((en_q & ~$past(en_q)) == '0))); // R2
endmodule

bind prio_irq_ctrl irqc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mask_i   (mask_i),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .irq_done (irq_done),
    .run_level(run_level),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .en_q     (en_q)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_i;
    logic        mask_i;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [4:0]  irq_vec;
    logic        irq_ack;
    logic        irq_done;
    logic [3:0]  run_level;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .irq_i(irq_i), .mask_i(mask_i),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .irq_done(irq_done), .run_level(run_level)
    );

    // {write, addr, wdata, expected read}
    localparam logic [76:0] VEC_TBL [12] = '{
        {1'b1, 12'h100, 32'h0000_00F0, 32'h0},
        {1'b0, 12'h100, 32'h0,         32'h0000_00F0},   // R1
        {1'b1, 12'h100, 32'h0000_0003, 32'h0},
        {1'b0, 12'h100, 32'h0,         32'h0000_00F3},   // R1
        {1'b1, 12'h180, 32'h0000_0021, 32'h0},
        {1'b0, 12'h180, 32'h0,         32'h0000_00D2},   // R2
        {1'b1, 12'h41C, 32'hFFA0_1234, 32'h0},
        {1'b0, 12'h41C, 32'h0,         32'hE0A0_0020},   // R3
        {1'b0, 12'h400, 32'h0,         32'h0},           // R3
        {1'b0, 12'h104, 32'h0,         32'h0},           // R2
        {1'b1, 12'h180, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 12'h100, 32'h0,         32'h0}            // R2
    };
    logic [76:0] v;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic raise(input int n);
        @(negedge clk);
        irq_i[n] = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input logic a, input logic d);
        @(negedge clk);
        irq_ack = a; irq_done = d;
        @(negedge clk);
        irq_ack = 1'b0; irq_done = 1'b0;
    endtask

    task automatic core_state(input string tag, input logic req, input logic [4:0] vec,
                              input logic [3:0] lvl);
        check({tag, " irq_req"}, {31'b0, irq_req}, {31'b0, req});
        if (req) check({tag, " irq_vec"}, {27'b0, irq_vec}, {27'b0, vec});
        check({tag, " run_level"}, {28'b0, run_level}, {28'b0, lvl});
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_i = '0; mask_i = 1'b0; reg_wr = 1'b0;
        reg_addr = '0; reg_wdata = '0; irq_ack = 1'b0; irq_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        reg_addr = 12'h100; #1;
        check("R10 enables after reset", reg_rdata, 32'h0);
        core_state("R10 reset", 1'b0, 5'd0, 4'd8);

        for (int i = 0; i < 12; i++) begin
            v = VEC_TBL[i];
            if (v[76]) begin
                wr(v[75:64], v[63:32]);
            end else begin
                reg_addr = v[75:64]; #1;
                check($sformatf("R1/R2/R3 table entry %0d", i), reg_rdata, v[31:0]);
            end
        end

        // priorities: 28->3, 29->2, 30->5, 31->7; 0..3 -> 2
        wr(12'h41C, 32'hE0A0_4060);
        wr(12'h400, 32'h4040_4040);
        wr(12'h100, 32'hF000_000C);

        raise(30);
        core_state("R6 idle preempt by 30", 1'b1, 5'd30, 4'd8);
        @(negedge clk); mask_i = 1'b1; #1;
        check("R9 masked irq_req", {31'b0, irq_req}, 32'h0);
        @(negedge clk); mask_i = 1'b0; #1;
        core_state("R9 pending kept after unmask", 1'b1, 5'd30, 4'd8);
        raise(31);
        core_state("R5 prio 5 beats 7", 1'b1, 5'd30, 4'd8);
        raise(29);
        core_state("R5 prio 2 wins", 1'b1, 5'd29, 4'd8);
        raise(3);
        core_state("R5 tie lowest number 3", 1'b1, 5'd3, 4'd8);
        raise(2);
        core_state("R5 tie lowest number 2", 1'b1, 5'd2, 4'd8);

        pulse(1'b1, 1'b0);
        core_state("R7 accept 2 and R6 equal blocked", 1'b0, 5'd0, 4'd2);

        wr(12'h400, 32'h4040_0040);    // irq1 -> 0
        raise(1);
        core_state("R4 disabled line stays silent", 1'b0, 5'd0, 4'd2);
        wr(12'h100, 32'h0000_0002);
        core_state("R4 signalled once enabled", 1'b1, 5'd1, 4'd2);
        pulse(1'b1, 1'b0);
        core_state("R7 nested accept 1", 1'b0, 5'd0, 4'd0);
        pulse(1'b0, 1'b1);
        core_state("R8 pop to 2", 1'b0, 5'd0, 4'd2);
        pulse(1'b0, 1'b1);
        core_state("R8 pop to idle", 1'b1, 5'd3, 4'd8);

        pulse(1'b1, 1'b0);
        core_state("R7 accept 3", 1'b0, 5'd0, 4'd2);
        pulse(1'b0, 1'b1);
        core_state("R4 held line 3 not relatched", 1'b1, 5'd29, 4'd8);
        pulse(1'b0, 1'b1);
        core_state("R8 done while idle", 1'b1, 5'd29, 4'd8);
        pulse(1'b1, 1'b1);
        core_state("R8 ack ignored with done", 1'b1, 5'd29, 4'd8);
        pulse(1'b1, 1'b0);
        core_state("R7 accept 29", 1'b0, 5'd0, 4'd2);
        pulse(1'b1, 1'b0);
        core_state("R7 ack without request", 1'b0, 5'd0, 4'd2);
        pulse(1'b0, 1'b1);
        core_state("R8 back to idle", 1'b1, 5'd30, 4'd8);

        @(negedge clk); irq_i[3] = 1'b0;
        raise(3);
        core_state("R4 new rising edge on 3", 1'b1, 5'd3, 4'd8);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        reg_addr = 12'h100; #1;
        check("R10 enables after second reset", reg_rdata, 32'h0);
        reg_addr = 12'h41C; #1;
        check("R10 priorities after second reset", reg_rdata, 32'h0);
        core_state("R10 second reset", 1'b0, 5'd0, 4'd8);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule